// File: doc/BRIEF.md
# Interleaved Memory Bank Conflict Arbiter

This block sits in front of a 16-way interleaved memory. On every clock it decides whether one reference may start. The candidates are a scalar reference, an I/O reference, a fetch and an exchange. The decision is made within the same clock, and at most one reference is granted per cycle.

A bank stays busy for four clocks after it is referenced. To enforce this, the block records the bank number (the low address bits) of every granted scalar or I/O reference in a short shift pipeline of ranks. A new scalar or I/O request is compared with every rank and is refused when any rank holds the same bank number.

An I/O request has the lowest priority. It also gives way to a list of machine conditions. When an I/O request is refused, it must stay away for a fixed retry interval. A fetch or an exchange may start only when no bank is busy. Once one has started, it locks out all other references until the controller signals that it has finished.

Top module: `membank_arbiter`

## Requirements
- R1: After reset all ranks are empty. `mem_quiet` is 1, `mem_lock` is 0 and `io_wait` is 0, and no grant is raised while no request is present.
- R2: A granted scalar or I/O reference enters rank A at the next clock edge. It then moves to rank B and then to rank C, one rank per clock, and then leaves the pipeline. Its bank therefore refuses new requests in the three cycles after the grant, and a request in the fourth cycle after the grant is accepted.
- R3: The bank number is the low 4 bits of the address. Two addresses conflict exactly when these 4 bits are equal, whatever their upper bits are.
- R4: A scalar or I/O request whose bank number equals a valid rank is not granted. For the scalar side, `scl_conflict` is 1 in that cycle.
- R5: In the first cycle of a scalar conflict (a conflict cycle whose previous cycle was not a hold), ranks A and B keep their contents and rank C becomes empty. In the next cycle the pipeline shifts normally even if the conflict persists. As a result, a scalar request that keeps asking for the bank it was just granted is accepted 6 cycles after its grant.
- R6: When a scalar request and an I/O request arrive in the same cycle, the scalar request is served and the I/O request is refused. No more than one of the four grants is ever high in the same cycle.
- R7: An I/O request is refused whenever any of the following is 1 in its cycle: `scl_req`, `scl_cp2`, `fetch_req`, `xchg_req`, `blk_op`, `sync_req` or `mem_lock`. It is also refused on a rank match.
- R8: When an I/O request is refused for any reason, `io_wait` is 1 for the next 7 cycles and `io_req` is ignored during that time. The request is first considered again 8 cycles after the refusal.
- R9: `fetch_gnt` is 1 only when `fetch_req` is 1, all ranks are empty and `mem_lock` is 0. From the next cycle `mem_lock` is 1 and all scalar, I/O, fetch and exchange grants are 0. The cycle after `op_done` is 1, `mem_lock` is 0 again.
- R10: An exchange is granted under the same quiet and unlocked conditions as a fetch, and it sets the lock in the same way. When a fetch and an exchange are both requested in the same cycle, the fetch wins.
- R11: `mem_quiet` is 1 exactly when no rank holds a valid entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_req | input | 1 | Scalar reference request |
| scl_addr | input | ADDR_W | Scalar reference address |
| scl_cp2 | input | 1 | A scalar reference is in its second clock period |
| io_req | input | 1 | I/O reference request |
| io_addr | input | ADDR_W | I/O reference address |
| fetch_req | input | 1 | Instruction fetch request |
| xchg_req | input | 1 | Exchange sequence request |
| blk_op | input | 1 | A block-transfer style instruction is in progress |
| sync_req | input | 1 | Non-memory synchronising request pending |
| op_done | input | 1 | End of the current fetch or exchange |
| scl_gnt | output | 1 | Scalar reference granted this cycle |
| scl_conflict | output | 1 | Scalar request hit a busy bank |
| io_gnt | output | 1 | I/O reference granted this cycle |
| io_wait | output | 1 | I/O retry interval running |
| fetch_gnt | output | 1 | Fetch granted this cycle |
| xchg_gnt | output | 1 | Exchange granted this cycle |
| mem_lock | output | 1 | Fetch or exchange owns memory |
| mem_quiet | output | 1 | All ranks empty |

## Verification
The hardest situation to reach from the ports is the alternating hold and shift pattern of a scalar request that keeps asking for a bank that is still busy. The pattern only appears when the conflict lasts over several consecutive cycles, with each rank position passed through in turn. The bench grants a bank and then holds the same scalar request high without a gap. It checks that the grant comes exactly six cycles later and that `mem_quiet` rises only in that cycle. An exhaustive sweep over every bank pair and every spacing from one to four cycles covers the plain rank comparison for both requesters.

// File: rtl/mbarb_pkg.sv
package mbarb_pkg;

   typedef enum logic [1:0] {
      LK_FREE  = 2'd0,
      LK_FETCH = 2'd1,
      LK_XCHG  = 2'd2
   } lock_e;

endpackage

// File: rtl/mbarb_match.sv
module mbarb_match #(
   parameter int NUM_RANKS = 3,
   parameter int BANK_W    = 4
) (
   input  logic                              req,
   input  logic [BANK_W-1:0]                 bank,
   input  logic [NUM_RANKS-1:0]              rank_v,
   input  logic [NUM_RANKS-1:0][BANK_W-1:0]  rank_b,
   output logic                              hit
);

   logic [NUM_RANKS-1:0] per_rank;

   generate
      for (genvar i = 0; i < NUM_RANKS; i++) begin : g_cmp
         assign per_rank[i] = rank_v[i] && (rank_b[i] == bank);
      end
   endgenerate

   assign hit = req && (|per_rank);

endmodule

// File: rtl/mbarb_ranks.sv
module mbarb_ranks #(
   parameter int NUM_RANKS = 3,
   parameter int BANK_W    = 4,
   parameter int HOLD_RANK = 1
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              ld_valid,
   input  logic [BANK_W-1:0]                 ld_bank,
   input  logic                              conflict,
   output logic [NUM_RANKS-1:0]              rank_v,
   output logic [NUM_RANKS-1:0][BANK_W-1:0]  rank_b,
   output logic                              quiet
);

   localparam int CLR_RANK = HOLD_RANK + 1;

   generate
      if (NUM_RANKS < 2) begin : g_bad_depth
         $error("mbarb_ranks: NUM_RANKS must be at least 2");
      end
      if (HOLD_RANK < 0 || HOLD_RANK > NUM_RANKS - 2) begin : g_bad_hold
         $error("mbarb_ranks: HOLD_RANK must leave a rank after it");
      end
   endgenerate

   logic                              hold_q;
   logic                              hold;
   logic [NUM_RANKS-1:0]              v_q, v_d;
   logic [NUM_RANKS-1:0][BANK_W-1:0]  b_q, b_d;

   assign hold = conflict && !hold_q;

   generate
      for (genvar i = 0; i < NUM_RANKS; i++) begin : g_rank
         if (i == 0) begin : g_head
            always_comb begin
               if (hold) begin
                  v_d[i] = v_q[i];
                  b_d[i] = b_q[i];
               end else begin
                  v_d[i] = ld_valid;
                  b_d[i] = ld_bank;
               end
            end
         end else if (i <= HOLD_RANK) begin : g_held
            always_comb begin
               if (hold) begin
                  v_d[i] = v_q[i];
                  b_d[i] = b_q[i];
               end else begin
                  v_d[i] = v_q[i-1];
                  b_d[i] = b_q[i-1];
               end
            end
         end else if (i == CLR_RANK) begin : g_clear
            always_comb begin
               if (hold) begin
                  v_d[i] = 1'b0;
                  b_d[i] = b_q[i];
               end else begin
                  v_d[i] = v_q[i-1];
                  b_d[i] = b_q[i-1];
               end
            end
         end else begin : g_tail
            always_comb begin
               v_d[i] = v_q[i-1];
               b_d[i] = b_q[i-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v_q    <= '0;
         b_q    <= '0;
         hold_q <= 1'b0;
      end else begin
         v_q    <= v_d;
         b_q    <= b_d;
         hold_q <= hold;
      end
   end

   assign rank_v = v_q;
   assign rank_b = b_q;
   assign quiet  = ~|v_q;

   AST_LOAD_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_valid && !hold) |=> (v_q[0] && b_q[0] == $past(ld_bank))); // R2
   AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> (v_q[HOLD_RANK] == $past(v_q[HOLD_RANK]) && !v_q[CLR_RANK])); // R5
   AST_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      hold |-> !ld_valid); // R5

endmodule

// File: rtl/mbarb_retry.sv
module mbarb_retry #(
   parameter int RETRY = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic refuse,
   output logic waiting
);

   localparam int CW = (RETRY > 2) ? $clog2(RETRY) : 1;
   localparam logic [CW-1:0] LOAD = CW'(RETRY - 1);

   generate
      if (RETRY < 2) begin : g_bad_retry
         $error("mbarb_retry: RETRY must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (refuse) begin
         cnt_q <= LOAD;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign waiting = (cnt_q != '0);

   AST_RETRY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      refuse |=> (cnt_q == LOAD)); // R8
   AST_RETRY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (waiting && !refuse) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R8

endmodule

// File: rtl/membank_arbiter.sv
module membank_arbiter #(
   parameter int ADDR_W    = 22,
   parameter int NUM_BANKS = 16,
   parameter int NUM_RANKS = 3,
   parameter int HOLD_RANK = 1,
   parameter int RETRY     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_req,
   input  logic [ADDR_W-1:0] scl_addr,
   input  logic              scl_cp2,
   input  logic              io_req,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              fetch_req,
   input  logic              xchg_req,
   input  logic              blk_op,
   input  logic              sync_req,
   input  logic              op_done,
   output logic              scl_gnt,
   output logic              scl_conflict,
   output logic              io_gnt,
   output logic              io_wait,
   output logic              fetch_gnt,
   output logic              xchg_gnt,
   output logic              mem_lock,
   output logic              mem_quiet
);
   import mbarb_pkg::*;

   localparam int BANK_W = $clog2(NUM_BANKS);

   generate
      if ((1 << BANK_W) != NUM_BANKS) begin : g_bad_banks
         $error("membank_arbiter: NUM_BANKS must be a power of two");
      end
      if (BANK_W > ADDR_W) begin : g_bad_addr
         $error("membank_arbiter: address narrower than bank field");
      end
   endgenerate

   logic [BANK_W-1:0]                 scl_bank, io_bank, ld_bank;
   logic [NUM_RANKS-1:0]              rank_v;
   logic [NUM_RANKS-1:0][BANK_W-1:0]  rank_b;
   logic                              scl_hit, io_hit, io_live, io_blocked;
   logic                              io_refuse, ld_valid, quiet;
   lock_e                             lk_q, lk_d;

   assign scl_bank = scl_addr[BANK_W-1:0];
   assign io_bank  = io_addr[BANK_W-1:0];

   mbarb_match #(.NUM_RANKS(NUM_RANKS), .BANK_W(BANK_W)) u_scl_match (
      .req(scl_req), .bank(scl_bank), .rank_v(rank_v), .rank_b(rank_b), .hit(scl_hit)
   );

   mbarb_match #(.NUM_RANKS(NUM_RANKS), .BANK_W(BANK_W)) u_io_match (
      .req(io_live), .bank(io_bank), .rank_v(rank_v), .rank_b(rank_b), .hit(io_hit)
   );

   mbarb_ranks #(.NUM_RANKS(NUM_RANKS), .BANK_W(BANK_W), .HOLD_RANK(HOLD_RANK)) u_ranks (
      .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_bank(ld_bank),
      .conflict(scl_conflict), .rank_v(rank_v), .rank_b(rank_b), .quiet(quiet)
   );

   mbarb_retry #(.RETRY(RETRY)) u_retry (
      .clk(clk), .rst_n(rst_n), .refuse(io_refuse), .waiting(io_wait)
   );

   assign mem_lock  = (lk_q != LK_FREE);
   assign mem_quiet = quiet;

   assign fetch_gnt = fetch_req && quiet && !mem_lock;
   assign xchg_gnt  = xchg_req && quiet && !mem_lock && !fetch_req;

   assign scl_conflict = scl_hit;
   assign scl_gnt      = scl_req && !scl_hit && !mem_lock && !fetch_gnt && !xchg_gnt;

   assign io_live    = io_req && !io_wait;
   assign io_blocked = scl_req || scl_cp2 || fetch_req || xchg_req ||
                       blk_op || sync_req || mem_lock;
   assign io_gnt     = io_live && !io_hit && !io_blocked;
   assign io_refuse  = io_live && !io_gnt;

   assign ld_valid = scl_gnt || io_gnt;
   assign ld_bank  = scl_gnt ? scl_bank : io_bank;

   always_comb begin
      lk_d = lk_q;
      if (mem_lock && op_done) begin
         lk_d = LK_FREE;
      end else if (fetch_gnt) begin
         lk_d = LK_FETCH;
      end else if (xchg_gnt) begin
         lk_d = LK_XCHG;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lk_q <= LK_FREE;
      end else begin
         lk_q <= lk_d;
      end
   end

   AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({scl_gnt, io_gnt, fetch_gnt, xchg_gnt}) <= 1); // R6
   AST_LOCK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      mem_lock |-> !(scl_gnt || io_gnt || fetch_gnt || xchg_gnt)); // R9
   AST_LOCK_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_gnt || xchg_gnt) |=> mem_lock); // R10
   AST_WAIT_NO_IO: assert property (@(posedge clk) disable iff (!rst_n)
      io_wait |-> !io_gnt); // R8
   AST_CONFLICT_NO_GNT: assert property (@(posedge clk) disable iff (!rst_n)
      scl_conflict |-> !scl_gnt); // R4

endmodule

// File: tb/membank_arbiter_test.sv
module membank_arbiter_test;

   localparam int CLK_T  = 10;
   localparam int ADDR_W = 22;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              scl_req = 0, scl_cp2 = 0, io_req = 0;
   logic [ADDR_W-1:0] scl_addr = '0, io_addr = '0;
   logic              fetch_req = 0, xchg_req = 0, blk_op = 0, sync_req = 0, op_done = 0;
   logic              scl_gnt, scl_conflict, io_gnt, io_wait;
   logic              fetch_gnt, xchg_gnt, mem_lock, mem_quiet;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_T/2) clk = ~clk;

   membank_arbiter #(.ADDR_W(ADDR_W)) uut (
      .clk(clk), .rst_n(rst_n), .scl_req(scl_req), .scl_addr(scl_addr),
      .scl_cp2(scl_cp2), .io_req(io_req), .io_addr(io_addr),
      .fetch_req(fetch_req), .xchg_req(xchg_req), .blk_op(blk_op),
      .sync_req(sync_req), .op_done(op_done), .scl_gnt(scl_gnt),
      .scl_conflict(scl_conflict), .io_gnt(io_gnt), .io_wait(io_wait),
      .fetch_gnt(fetch_gnt), .xchg_gnt(xchg_gnt), .mem_lock(mem_lock),
      .mem_quiet(mem_quiet)
   );

   task automatic check(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic settle();
      #2;
   endtask

   task automatic idle(input int n);
      scl_req = 0; io_req = 0; fetch_req = 0; xchg_req = 0;
      scl_cp2 = 0; blk_op = 0; sync_req = 0; op_done = 0;
      for (int k = 0; k < n; k++) tick();
   endtask

   function automatic logic [ADDR_W-1:0] mk_addr(input int bank, input int salt);
      logic [ADDR_W-5:0] up;
      up = (ADDR_W-4)'(salt * 2654435 + 17);
      return {up, 4'(bank)};
   endfunction

   initial begin
      #(CLK_T * 150000);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      settle();
      // R1 reset state
      check("R1 quiet", mem_quiet, 1'b1);
      check("R1 lock", mem_lock, 1'b0);
      check("R1 wait", io_wait, 1'b0);
      check("R1 scl_gnt", scl_gnt, 1'b0);
      check("R1 io_gnt", io_gnt, 1'b0);
      tick();

      // R7 unblocked I/O request is granted
      io_req = 1; io_addr = mk_addr(5, 1);
      settle();
      check("R7 io free", io_gnt, 1'b1);
      idle(6);

      // R2 R3 R4 scalar sweep: bank pairs and spacing
      for (int b1 = 0; b1 < 16; b1++) begin
         for (int b2 = 0; b2 < 16; b2++) begin
            for (int d = 1; d <= 4; d++) begin
               scl_req = 1; scl_addr = mk_addr(b1, b2 + d);
               settle();
               check("R2 first grant", scl_gnt, 1'b1);
               tick();
               scl_req = 0;
               for (int k = 1; k < d; k++) tick();
               scl_req = 1; scl_addr = mk_addr(b2, b1 * 7 + d);
               settle();
               check("R3 R4 scalar bank compare", scl_gnt, (b1 != b2) || (d == 4));
               check("R4 conflict flag", scl_conflict, (b1 == b2) && (d != 4));
               tick();
               idle(7);
            end
         end
      end

      // R4 I/O sweep against a scalar-granted bank
      for (int b1 = 0; b1 < 16; b1++) begin
         for (int b2 = 0; b2 < 16; b2++) begin
            for (int d = 1; d <= 4; d++) begin
               scl_req = 1; scl_addr = mk_addr(b1, d);
               tick();
               scl_req = 0;
               for (int k = 1; k < d; k++) tick();
               io_req = 1; io_addr = mk_addr(b2, b1 + b2);
               settle();
               check("R4 io bank compare", io_gnt, (b1 != b2) || (d == 4));
               tick();
               idle(9);
            end
         end
      end

      // R5 hold pattern: same bank kept requesting after its grant
      scl_req = 1; scl_addr = mk_addr(3, 9);
      settle();
      check("R5 initial grant", scl_gnt, 1'b1);
      tick();
      for (int k = 1; k <= 6; k++) begin
         scl_addr = mk_addr(3, 100 + k);
         settle();
         check("R5 held grant timing", scl_gnt, k == 6);
         check("R11 quiet during hold", mem_quiet, k == 6);
         tick();
      end
      idle(6);

      // R6 scalar beats I/O in the same cycle
      scl_req = 1; scl_addr = mk_addr(2, 3);
      io_req = 1; io_addr = mk_addr(11, 4);
      settle();
      check("R6 scalar wins", scl_gnt, 1'b1);
      check("R6 io loses", io_gnt, 1'b0);
      tick();
      scl_req = 0; io_req = 1;
      settle();
      check("R8 wait after loss", io_wait, 1'b1);
      idle(10);

      // R7 each blocker alone refuses I/O
      for (int c = 0; c < 6; c++) begin
         io_req = 1; io_addr = mk_addr(5, c);
         scl_cp2  = (c == 0);
         fetch_req = (c == 1);
         blk_op   = (c == 2);
         xchg_req = (c == 3);
         sync_req = (c == 4);
         scl_req  = (c == 5);
         scl_addr = mk_addr(9, c);
         settle();
         check("R7 blocker refuses io", io_gnt, 1'b0);
         tick();
         io_req = 0; scl_cp2 = 0; fetch_req = 0; blk_op = 0;
         xchg_req = 0; sync_req = 0; scl_req = 0;
         op_done = 1;
         tick();
         idle(10);
      end

      // R8 retry interval
      io_req = 1; io_addr = mk_addr(6, 2); blk_op = 1;
      settle();
      check("R8 refused", io_gnt, 1'b0);
      tick();
      blk_op = 0;
      for (int k = 1; k <= 8; k++) begin
         settle();
         check("R8 retry grant timing", io_gnt, k == 8);
         check("R8 wait flag", io_wait, k != 8);
         tick();
      end
      idle(6);

      // R9 fetch needs quiet memory, then locks
      scl_req = 1; scl_addr = mk_addr(1, 5);
      tick();
      scl_req = 0; fetch_req = 1;
      for (int k = 1; k <= 4; k++) begin
         settle();
         check("R9 fetch waits for quiet", fetch_gnt, k == 4);
         check("R11 quiet tracks ranks", mem_quiet, k == 4);
         tick();
      end
      fetch_req = 0;
      settle();
      check("R9 lock set", mem_lock, 1'b1);
      scl_req = 1; scl_addr = mk_addr(4, 1);
      io_req = 1; io_addr = mk_addr(8, 1);
      fetch_req = 1;
      settle();
      check("R9 lock blocks scalar", scl_gnt, 1'b0);
      check("R9 lock blocks io", io_gnt, 1'b0);
      check("R9 lock blocks fetch", fetch_gnt, 1'b0);
      tick();
      scl_req = 0; io_req = 0; fetch_req = 0;
      op_done = 1;
      tick();
      op_done = 0;
      settle();
      check("R9 lock released", mem_lock, 1'b0);
      scl_req = 1;
      settle();
      check("R9 scalar after release", scl_gnt, 1'b1);
      tick();
      idle(6);

      // R10 fetch beats exchange, exchange alone locks
      fetch_req = 1; xchg_req = 1;
      settle();
      check("R10 fetch wins", fetch_gnt, 1'b1);
      check("R10 exchange loses", xchg_gnt, 1'b0);
      tick();
      fetch_req = 0; xchg_req = 0; op_done = 1;
      tick();
      op_done = 0;
      xchg_req = 1;
      settle();
      check("R10 exchange alone", xchg_gnt, 1'b1);
      tick();
      xchg_req = 0;
      settle();
      check("R10 exchange locks", mem_lock, 1'b1);
      op_done = 1;
      tick();
      idle(2);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule